// File: doc/BRIEF.md
# PCI Target Claim Decoder

This block watches the address phase of a PCI transaction on behalf of one target and decides whether that target takes the cycle and in which clock it says so. A positive decode covers I/O commands that land inside a programmed byte window and configuration commands in either of the two address formats. The claim signal rises after a delay of one, two or three clocks, chosen by a two-bit timing field. A separate subtractive mode lets the target pick up any cycle that no agent on the bus has claimed after three clocks.

For an I/O cycle the block latches the address. It then compares every byte lane that the first data phase enables against the window. If any enabled byte falls outside the window, the block raises a target-abort request, and the data path ends the cycle without moving data. The block also reports a code for the kind of access it claimed, so that the data path can route the cycle. Data movement is left to the surrounding logic. That logic drives TRDY or STOP and observes the claim and abort outputs.

Top module: `pcit_decode_top`

## Requirements
- R1: While reset is asserted and just after it is released, `devsel` and `tabort_req` are low and `acc_type` is 0.
- R2: The address phase is the first clock in which `frame` is high after a clock in which it was low. For a positive decode, `devsel` is first seen high in clock 1, 2 or 3 after the address phase when `dsel_timing` is 00, 01 or 10 respectively. The code 11 behaves like 10.
- R3: A command on `cbe_n` of 0010 or 0011 (I/O) is positively decoded exactly when the 32-bit byte address on `ad` lies in the inclusive range [`io_base`, `io_limit`].
- R4: A command of 1010 or 1011 (configuration) is positively decoded in two cases. If `ad[1:0]` = 00 and `idsel` is high, the cycle is type 0. If `ad[1:0]` = 01, the cycle is type 1. Configuration cycles with `ad[1:0]` of 10 or 11 are never positively decoded, and neither is type 0 without `idsel`.
- R5: With `sub_en` high, a cycle that is not positively decoded is claimed in clock 4 after the address phase, but only if `ext_devsel` was low when sampled in clocks 1, 2 and 3. Otherwise it is not claimed.
- R6: For a claimed I/O cycle, the byte enables are taken from `cbe_n` in clock 1 (active low, lane i = byte address {AD[31:2], i}). If any enabled lane lies outside the window, `tabort_req` is high from clock 2, or from the claim if that comes later, until `devsel` falls. If no enabled lane lies outside the window, including when no lane is enabled, `tabort_req` stays low.
- R7: Once high, `devsel` stays high until the clock in which `frame` is low, `irdy` is high and `trdy` or `stop` is high. It is low in the following clock.
- R8: While `devsel` is high, `acc_type` is constant: 1 for I/O, 2 for configuration type 0, 3 for configuration type 1, 4 for a subtractive claim. It is 0 whenever `devsel` is low.
- R9: A cycle that is neither positively decoded nor subtractively claimed never raises `devsel`. The block returns to idle when the initiator drops `frame` and `irdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame | input | 1 | Initiator frame, high while the cycle runs |
| irdy | input | 1 | Initiator ready |
| trdy | input | 1 | Target ready from the data path |
| stop | input | 1 | Target stop from the data path |
| idsel | input | 1 | Configuration select for type 0 cycles |
| ad | input | AW | Address/data bus |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables afterwards |
| ext_devsel | input | 1 | Claim seen from any other agent |
| sub_en | input | 1 | Enables subtractive claim |
| dsel_timing | input | 2 | Claim delay: 00 fast, 01 medium, 10/11 slow |
| io_base | input | AW | Lowest byte address of the I/O window |
| io_limit | input | AW | Highest byte address of the I/O window |
| devsel | output | 1 | Claim of the current cycle |
| tabort_req | output | 1 | Request to end the cycle with target-abort |
| acc_type | output | 3 | Kind of claimed access |

## Verification
The bench sweeps every timing code across I/O, configuration and memory commands. It places addresses on and just past both window edges, uses every configuration format, and runs each case with subtractive mode off and with another agent claiming in clock 1, 2 or 3. A claim one clock off, or a code 11 not treated as slow, shows up as a wrong claim clock. A subtractive claim that ignores a clock-3 claim from another agent shows up as a claim where none is allowed. All sixteen byte-enable patterns are tried at both window edges, which exposes a range check with an off-by-one error or a wrong lane order. Frames held for several extra clocks catch a `devsel` that drops before the final data phase, or one that stays high one clock too long.

// File: rtl/pcit_pkg.sv
package pcit_pkg;

    localparam int NLANE = 4;

    typedef enum logic [2:0] {
        ACC_NONE = 3'd0,
        ACC_IO   = 3'd1,
        ACC_CFG0 = 3'd2,
        ACC_CFG1 = 3'd3,
        ACC_SUB  = 3'd4
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SUBW,
        ST_CLAIM
    } st_e;

    // upper three command bits; bit 0 only selects read or write
    localparam logic [2:0] CMD_IO  = 3'b001;
    localparam logic [2:0] CMD_CFG = 3'b101;

    localparam logic [1:0] CFG_TYPE0 = 2'b00;
    localparam logic [1:0] CFG_TYPE1 = 2'b01;

endpackage

// File: rtl/pcit_cmd_decode.sv
module pcit_cmd_decode
    import pcit_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [2:0]    cmd_hi,
    input  logic [AW-1:0] ad,
    input  logic          idsel,
    input  logic [AW-1:0] io_base,
    input  logic [AW-1:0] io_limit,
    output acc_e          kind
);

    logic in_window;

    always_comb begin
        in_window = (ad >= io_base) && (ad <= io_limit);
        kind      = ACC_NONE;
        if (cmd_hi == CMD_IO) begin
            if (in_window) kind = ACC_IO;
        end else if (cmd_hi == CMD_CFG) begin
            if (ad[1:0] == CFG_TYPE0 && idsel) kind = ACC_CFG0;
            else if (ad[1:0] == CFG_TYPE1)     kind = ACC_CFG1;
        end
    end

endmodule

// File: rtl/pcit_lane_check.sv
module pcit_lane_check
    import pcit_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-LW-1:0] adr_w,
    input  logic [NLANE-1:0] be_n,
    input  logic [AW-1:0]    base,
    input  logic [AW-1:0]    limit,
    output logic             bad
);

    localparam int LW = $clog2(NLANE);

    logic [NLANE-1:0] lane_out;

    genvar gi;
    generate
        for (gi = 0; gi < NLANE; gi++) begin : g_lane
            logic [AW-1:0] lane_addr;
            assign lane_addr    = {adr_w, LW'(gi)};
            assign lane_out[gi] = !be_n[gi] && ((lane_addr < base) || (lane_addr > limit));
        end
    endgenerate

    assign bad = |lane_out;

endmodule

// File: rtl/pcit_claim_ctl.sv
module pcit_claim_ctl
    import pcit_pkg::*;
#(
    parameter int AW       = 32,
    parameter int SUB_CLKS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame,
    input  logic             irdy,
    input  logic             trdy,
    input  logic             stop,
    input  logic             ext_devsel,
    input  logic             sub_en,
    input  logic [1:0]       tsel,
    input  acc_e             kind_in,
    input  logic             lane_bad,
    input  logic [AW-LW-1:0] ad_w,
    output logic [AW-LW-1:0] lat_w,
    output logic             devsel,
    output logic             tabort,
    output acc_e             acc_type
);

    localparam int LW = $clog2(NLANE);
    localparam int CW = $clog2(SUB_CLKS + 2);
    localparam logic [CW-1:0] CMAX = '1;
    localparam logic [CW-1:0] C_ONE = CW'(1);

    typedef struct packed {
        st_e              st;
        logic [CW-1:0]    cnt;
        acc_e             kind;
        logic             bad;
        logic             frame_p;
        logic [AW-LW-1:0] adr;
    } ctl_t;

    ctl_t          q, d;
    logic          addr_ph, fin, quit, bad_now;
    logic [CW-1:0] dly, cnt_nx;

    always_comb begin
        addr_ph = frame && !q.frame_p;
        fin     = !frame && irdy && (trdy || stop);
        quit    = !frame && !irdy;
        case (tsel)
            2'b00:   dly = CW'(1);
            2'b01:   dly = CW'(2);
            default: dly = CW'(3);
        endcase
        cnt_nx  = (q.cnt == CMAX) ? q.cnt : q.cnt + C_ONE;
        bad_now = (q.cnt == C_ONE) ? lane_bad : q.bad;

        d         = q;
        d.frame_p = frame;
        case (q.st)
            ST_IDLE: begin
                d.cnt  = C_ONE;
                d.bad  = 1'b0;
                d.kind = ACC_NONE;
                if (addr_ph) begin
                    d.adr = ad_w;
                    if (kind_in != ACC_NONE) begin
                        d.kind = kind_in;
                        d.st   = (dly == C_ONE) ? ST_CLAIM : ST_WAIT;
                    end else if (sub_en) begin
                        d.kind = ACC_SUB;
                        d.st   = ST_SUBW;
                    end
                end
            end
            ST_WAIT: begin
                d.cnt = cnt_nx;
                d.bad = bad_now;
                if (quit) begin
                    d.st   = ST_IDLE;
                    d.kind = ACC_NONE;
                end else if (q.cnt == dly - C_ONE) begin
                    d.st = ST_CLAIM;
                end
            end
            ST_SUBW: begin
                d.cnt = cnt_nx;
                if (quit || ext_devsel) begin
                    d.st   = ST_IDLE;
                    d.kind = ACC_NONE;
                end else if (q.cnt == CW'(SUB_CLKS)) begin
                    d.st = ST_CLAIM;
                end
            end
            default: begin
                d.cnt = cnt_nx;
                d.bad = bad_now;
                if (fin) begin
                    d.st   = ST_IDLE;
                    d.kind = ACC_NONE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, kind: ACC_NONE, bad: 1'b0, frame_p: 1'b0, adr: '0};
        end else begin
            q <= d;
        end
    end

    assign devsel   = (q.st == ST_CLAIM);
    assign tabort   = devsel && (q.kind == ACC_IO) && q.bad;
    assign acc_type = devsel ? q.kind : ACC_NONE;
    assign lat_w    = q.adr;

    AST_FAST_CLAIM: assert property (@(posedge clk) disable iff (!rst_n) (q.st == ST_IDLE && addr_ph && kind_in != ACC_NONE && tsel == 2'b00) |=> devsel); // R2
    AST_DEVSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (devsel && !(!frame && irdy && (trdy || stop))) |=> devsel); // R7
    AST_DEVSEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (devsel && !frame && irdy && (trdy || stop)) |=> !devsel); // R7
    AST_SUB_UNCONTESTED: assert property (@(posedge clk) disable iff (!rst_n) ($rose(devsel) && acc_type == ACC_SUB) |-> !$past(ext_devsel)); // R5
    AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (devsel && $past(devsel) && $past(tabort)) |-> tabort); // R6
    AST_TYPE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (devsel && $past(devsel)) |-> $stable(acc_type)); // R8

endmodule

// File: rtl/pcit_decode_top.sv
module pcit_decode_top
    import pcit_pkg::*;
#(
    parameter int AW       = 32,
    parameter int SUB_CLKS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame,
    input  logic             irdy,
    input  logic             trdy,
    input  logic             stop,
    input  logic             idsel,
    input  logic [AW-1:0]    ad,
    input  logic [NLANE-1:0] cbe_n,
    input  logic             ext_devsel,
    input  logic             sub_en,
    input  logic [1:0]       dsel_timing,
    input  logic [AW-1:0]    io_base,
    input  logic [AW-1:0]    io_limit,
    output logic             devsel,
    output logic             tabort_req,
    output logic [2:0]       acc_type
);

    localparam int LW = $clog2(NLANE);

    acc_e             kind;
    acc_e             acc_q;
    logic             lane_bad;
    logic [AW-LW-1:0] lat_w;

    pcit_cmd_decode #(.AW(AW)) u_cmd (
        .cmd_hi   (cbe_n[3:1]),
        .ad       (ad),
        .idsel    (idsel),
        .io_base  (io_base),
        .io_limit (io_limit),
        .kind     (kind)
    );

    pcit_lane_check #(.AW(AW)) u_lane (
        .adr_w (lat_w),
        .be_n  (cbe_n),
        .base  (io_base),
        .limit (io_limit),
        .bad   (lane_bad)
    );

    pcit_claim_ctl #(.AW(AW), .SUB_CLKS(SUB_CLKS)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame      (frame),
        .irdy       (irdy),
        .trdy       (trdy),
        .stop       (stop),
        .ext_devsel (ext_devsel),
        .sub_en     (sub_en),
        .tsel       (dsel_timing),
        .kind_in    (kind),
        .lane_bad   (lane_bad),
        .ad_w       (ad[AW-1:LW]),
        .lat_w      (lat_w),
        .devsel     (devsel),
        .tabort     (tabort_req),
        .acc_type   (acc_q)
    );

    assign acc_type = acc_q;

endmodule

// File: tb/sim_pcit_decode_top.sv
`timescale 1ns/1ps
module sim_pcit_decode_top;

    localparam logic [31:0] WBASE = 32'h0000_1002;
    localparam logic [31:0] WLIM  = 32'h0000_100D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame = 1'b0, irdy = 1'b0, trdy = 1'b0, stop = 1'b0, idsel = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        ext = 1'b0, sub = 1'b0;
    logic [1:0]  tsel = 2'b00;
    logic        devsel, tab;
    logic [2:0]  acc_type;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pcit_decode_top #(.AW(32)) u0 (
        .clk(clk), .rst_n(rst_n), .frame(frame), .irdy(irdy), .trdy(trdy), .stop(stop),
        .idsel(idsel), .ad(ad), .cbe_n(cbe_n), .ext_devsel(ext), .sub_en(sub),
        .dsel_timing(tsel), .io_base(WBASE), .io_limit(WLIM),
        .devsel(devsel), .tabort_req(tab), .acc_type(acc_type)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_kind(input logic [3:0] cmd, input logic [31:0] a, input logic ids);
        if (cmd[3:1] == 3'b001) return (a >= WBASE && a <= WLIM) ? 1 : 0;
        if (cmd[3:1] == 3'b101) begin
            if (a[1:0] == 2'b00) return ids ? 2 : 0;
            if (a[1:0] == 2'b01) return 3;
        end
        return 0;
    endfunction

    function automatic int exp_abort(input int k, input logic [31:0] a, input logic [3:0] be);
        logic [31:0] b;
        if (k != 1) return 0;
        for (int i = 0; i < 4; i++) begin
            b = {a[31:2], 2'b00} + 32'(i);
            if (!be[i] && (b < WBASE || b > WLIM)) return 1;
        end
        return 0;
    endfunction

    task automatic txn(input logic [3:0] cmd, input logic [31:0] a, input logic [3:0] be,
                       input logic ids, input int ts, input logic sb, input int extc, input int fclk);
        int first = 0, len = 0, typ = 0, ab = 0;
        int ek, ef, ea, el, endc;
        string tg;
        @(negedge clk);
        tsel = 2'(ts); sub = sb;
        frame = 1'b1; ad = a; cbe_n = cmd; idsel = ids;
        irdy = 1'b0; trdy = 1'b0; stop = 1'b0; ext = 1'b0;
        for (int k = 1; k <= 14; k++) begin
            @(negedge clk);
            if (devsel) begin
                if (first == 0) begin first = k; typ = int'(acc_type); end
                len++;
                if (tab) ab = 1;
            end else if (first != 0) begin
                break;
            end
            if (first == 0 && k >= 6) break;
            cbe_n = (k == 1) ? be : 4'hF;
            ad    = 32'h5A5A_0000 + 32'(k);
            idsel = 1'b0;
            frame = (k < fclk) && !(first == 0 && k >= 5);
            irdy  = !(first == 0 && k >= 5);
            ext   = (k == extc);
            if (first != 0 && k >= first + 1) begin
                if (ab != 0) stop = 1'b1; else trdy = 1'b1;
            end
        end
        frame = 1'b0; irdy = 1'b0; trdy = 1'b0; stop = 1'b0; ext = 1'b0;
        ad = '0; cbe_n = 4'hF;

        ek = exp_kind(cmd, a, ids);
        ea = exp_abort(ek, a, be);
        if (ek != 0) ef = (ts == 0) ? 1 : (ts == 1) ? 2 : 3;          // R2 codes 00/01/10, 11 slow
        else if (sb && extc == 0) begin ef = 4; ek = 4; end           // R5
        else ef = 0;                                                   // R9
        endc = (fclk > ef + 1) ? fclk : ef + 1;
        el = (ef == 0) ? 0 : endc - ef + 1;
        tg = (ek == 4) ? "R5" : (ek == 1) ? "R3" : (ek >= 2) ? "R4" : "R9";
        chk(tg, "claim clock (R2 timing)", first, ef);
        chk("R8", "access type", typ, ek);
        if (ef != 0) chk("R7", "devsel length", len, el);
        chk("R6", "target abort", ab, ea);
        @(negedge clk);
    endtask

    initial begin
        logic [3:0]  sc_cmd [11];
        logic [31:0] sc_adr [11];
        logic        sc_ids [11];
        sc_cmd = '{4'h2, 4'h3, 4'h2, 4'h2, 4'h3, 4'hA, 4'hB, 4'hA, 4'hA, 4'hB, 4'h6};
        sc_adr = '{32'h1004, 32'h1002, 32'h100C, 32'h1001, 32'h100E,
                   32'h0000_0800, 32'h0000_0800, 32'h0001_0201, 32'h0001_0202, 32'h0001_0203, 32'h1004};
        sc_ids = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

        repeat (3) @(negedge clk);
        chk("R1", "devsel in reset", int'(devsel), 0);
        chk("R1", "abort in reset", int'(tab), 0);
        chk("R1", "type in reset", int'(acc_type), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "devsel after reset", int'(devsel), 0);
        chk("R1", "type after reset", int'(acc_type), 0);

        // R2 R3 R4 R5 R9: every timing code over every command scenario
        for (int ts = 0; ts < 4; ts++)
            for (int s = 0; s < 11; s++)
                for (int sb = 0; sb < 2; sb++)
                    for (int ec = 0; ec <= (sb != 0 ? 3 : 0); ec++)
                        txn(sc_cmd[s], sc_adr[s], 4'h0, sc_ids[s], ts, sb[0], ec, 1);

        // R6: every byte-enable pattern at both window edges and inside
        for (int b = 0; b < 16; b++) begin
            txn(4'h3, 32'h1002, 4'(b), 1'b0, b % 4, 1'b0, 0, 1);
            txn(4'h2, 32'h100C, 4'(b), 1'b0, (b + 1) % 4, 1'b0, 0, 1);
            txn(4'h2, 32'h1004, 4'(b), 1'b0, (b + 2) % 4, 1'b1, 0, 1);
        end

        // R7: multi-phase frames hold the claim
        for (int f = 2; f <= 6; f++)
            for (int ts = 0; ts < 4; ts++) begin
                txn(4'h2, 32'h1004, 4'h0, 1'b0, ts, 1'b0, 0, f);
                txn(4'h3, 32'h100C, 4'h3, 1'b0, ts, 1'b0, 0, f);
            end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1..all actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule